// File: doc/BRIEF.md
# Dual-Port RAM with Held Output Register

A true dual-port synchronous memory. Each of its two ports has its own clock, enable, write enable, synchronous set input, address, write data and registered read data. The output register of a port follows a no-change policy. A write cycle stores data into the array, and the port's read data keeps the last word it read. The output register takes a new word from the array only on a read cycle.

Each port has two constants of its own. One is the value its output register holds after reset. The other is the value that the set input forces into the output register. The array starts with computed contents: word i holds `INIT_BASE + i*INIT_STEP`, modulo 2^DW. A parameter can invert each control input, including each clock. Both ports may write on the same edge. If they write the same address, port A's data is kept. Data that one port wrote on an earlier edge can be read at once through the other port.

Top module: `dpram_nochg`

## Requirements
- R1: While `rst_n` is low on a port's clock edge, that port's read data becomes its reset constant (`INIT_A` / `INIT_B`). This constant is independent of the set constant.
- R2: After reset, array word i reads back as `INIT_BASE + i*INIT_STEP` modulo 2^DW.
- R3: A read cycle (enable active, write enable inactive, set inactive) loads the word at the port address into the read data on that clock edge.
- R4: A write cycle (enable and write enable active, set inactive) stores the write data at the address and leaves the port's read data unchanged.
- R5: With enable inactive, the edge changes neither the array nor the port's read data, whatever the other inputs are.
- R6: With enable and set both active, the read data becomes `SRVAL_A` / `SRVAL_B`. This takes priority over a read.
- R7: Set together with a write still stores the write data into the array.
- R8: A read through one port returns data that the other port wrote on an earlier edge.
- R9: When both ports write the same address on the same edge, the array keeps port A's data.
- R10: Each control input and each clock has a parameter that inverts it. When the parameter is 1, the input is active low, and the port clock acts on its falling edge.
- R11: The two ports work independently. Simultaneous operations at different addresses do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled by each port clock |
| clk_a | input | 1 | Port A clock (polarity by INV_CLK_A) |
| en_a | input | 1 | Port A enable (polarity by INV_EN_A) |
| we_a | input | 1 | Port A write enable (polarity by INV_WE_A) |
| ssr_a | input | 1 | Port A synchronous set to SRVAL_A (polarity by INV_SSR_A) |
| addr_a | input | AW | Port A word address |
| din_a | input | DW | Port A write data |
| dout_a | output | DW | Port A registered read data |
| clk_b | input | 1 | Port B clock (polarity by INV_CLK_B) |
| en_b | input | 1 | Port B enable (polarity by INV_EN_B) |
| we_b | input | 1 | Port B write enable (polarity by INV_WE_B) |
| ssr_b | input | 1 | Port B synchronous set to SRVAL_B (polarity by INV_SSR_B) |
| addr_b | input | AW | Port B word address |
| din_b | input | DW | Port B write data |
| dout_b | output | DW | Port B registered read data |

## Verification
Directed sequences come first. A read of untouched words tells the computed start contents apart from a zeroed array. A write followed by an idle cycle, then a read, separates holding the output from write-through. Set with and without write enable shows that set wins over a read but does not block the store. Crossed write-then-read between the ports and same-address double writes expose missing merge or priority logic. A random phase on a narrow address range then mixes every operation on both ports, with the enable of port A, the write enable of port B and the set of port B inverted. Any polarity slip shows up as a miscompare against the reference model.

// File: rtl/dpram_nochg_pkg.sv
// Package: types shared by the no-change dual-port RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package dpram_nochg_pkg;

    // Operation a port performs on one clock edge, after polarity handling.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SET   = 2'd3
    } port_op_e;

endpackage

// File: rtl/dpram_nochg_front.sv
// Module: per-port front end. Removes the optional inversion from the clock
// and the control pins, then classifies the edge as idle, read, write or set.
// Assumes: set takes priority over read and write for the output register;
// the array write strobe is independent of set.
module dpram_nochg_front
    import dpram_nochg_pkg::*;
#(
    parameter bit INV_CLK = 1'b0,
    parameter bit INV_EN  = 1'b0,
    parameter bit INV_WE  = 1'b0,
    parameter bit INV_SSR = 1'b0
) (
    input  logic     clk_pin,
    input  logic     en_pin,
    input  logic     we_pin,
    input  logic     ssr_pin,
    output logic     clk_int,
    output port_op_e op,
    output logic     wr_req
);

    logic en_i;
    logic we_i;
    logic ssr_i;

    // Polarity correction of clock and controls.
    assign clk_int = clk_pin ^ INV_CLK;
    assign en_i    = en_pin  ^ INV_EN;
    assign we_i    = we_pin  ^ INV_WE;
    assign ssr_i   = ssr_pin ^ INV_SSR;

    // Array write request: enable and write enable, set does not block it.
    assign wr_req = en_i & we_i;

    // Output register operation with set above write above read.
    always_comb begin
        if (!en_i) begin
            op = OP_IDLE;
        end else if (ssr_i) begin
            op = OP_SET;
        end else if (we_i) begin
            op = OP_WRITE;
        end else begin
            op = OP_READ;
        end
    end

endmodule

// File: rtl/dpram_nochg_bank.sv
// Module: one write bank of the merged dual-port array. It is written by a
// single clock only, keeps a tag bit per word, and offers two asynchronous
// read ports for data and tag plus a tag probe for the peer bank.
// Assumes: the newest copy of a word is in the primary bank when the two
// tags are equal, and in the secondary bank when they differ. A primary
// write copies the peer tag; a secondary write stores its inverse.
module dpram_nochg_bank #(
    parameter int          AW        = 10,
    parameter int          DW        = 18,
    parameter bit          PRIMARY   = 1'b1,
    parameter logic [DW-1:0] INIT_BASE = '0,
    parameter logic [DW-1:0] INIT_STEP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          peer_tag,
    input  logic [AW-1:0] peer_addr,
    output logic          tag_at_peer,
    input  logic [AW-1:0] rd_addr0,
    output logic [DW-1:0] rd_word0,
    output logic          rd_tag0,
    input  logic [AW-1:0] rd_addr1,
    output logic [DW-1:0] rd_word1,
    output logic          rd_tag1
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] tags;
    logic             tag_next;

    // Tag rule for this bank's role (generate picks the variant).
    generate
        if (PRIMARY) begin : g_primary
            assign tag_next = peer_tag;
        end else begin : g_secondary
            assign tag_next = ~peer_tag;
        end
    endgenerate

    // Data store: computed start pattern on reset, then port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= INIT_BASE + DW'(i) * INIT_STEP;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Tag store: cleared on reset, marks ownership on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags <= '0;
        end else if (wr_en) begin
            tags[wr_addr] <= tag_next;
        end
    end

    // Asynchronous read taps for both ports and the peer probe.
    assign rd_word0    = mem[rd_addr0];
    assign rd_tag0     = tags[rd_addr0];
    assign rd_word1    = mem[rd_addr1];
    assign rd_tag1     = tags[rd_addr1];
    assign tag_at_peer = tags[peer_addr];

endmodule

// File: rtl/dpram_nochg_outreg.sv
// Module: per-port output register with the no-change policy. It loads the
// array word on a read, the set constant on a set, and holds otherwise.
// Assumes: rd_word is the merged array word at the port address, already
// settled before the clock edge.
module dpram_nochg_outreg
    import dpram_nochg_pkg::*;
#(
    parameter int            DW       = 18,
    parameter logic [DW-1:0] INIT_VAL = '0,
    parameter logic [DW-1:0] SET_VAL  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  port_op_e      op,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] dout
);

    // Output register update per the classified operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= INIT_VAL;
        end else begin
            case (op)
                OP_SET:  dout <= SET_VAL;
                OP_READ: dout <= rd_word;
                default: dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/dpram_nochg.sv
// Module: top of the no-change dual-port RAM. Two single-writer banks with
// per-word tags form one logical array, so that no storage element is
// written from two clocks. Port A wins a same-address write on a shared
// edge because port B suppresses its own write when it sees that case.
// Assumes: the same-address rule is defined only for coinciding edges.
module dpram_nochg
    import dpram_nochg_pkg::*;
#(
    parameter int            AW        = 10,
    parameter int            DW        = 18,
    parameter logic [DW-1:0] INIT_BASE = '0,
    parameter logic [DW-1:0] INIT_STEP = '0,
    parameter logic [DW-1:0] INIT_A    = '0,
    parameter logic [DW-1:0] SRVAL_A   = '0,
    parameter logic [DW-1:0] INIT_B    = '0,
    parameter logic [DW-1:0] SRVAL_B   = '0,
    parameter bit            INV_CLK_A = 1'b0,
    parameter bit            INV_EN_A  = 1'b0,
    parameter bit            INV_WE_A  = 1'b0,
    parameter bit            INV_SSR_A = 1'b0,
    parameter bit            INV_CLK_B = 1'b0,
    parameter bit            INV_EN_B  = 1'b0,
    parameter bit            INV_WE_B  = 1'b0,
    parameter bit            INV_SSR_B = 1'b0
) (
    input  logic          rst_n,
    input  logic          clk_a,
    input  logic          en_a,
    input  logic          we_a,
    input  logic          ssr_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] din_a,
    output logic [DW-1:0] dout_a,
    input  logic          clk_b,
    input  logic          en_b,
    input  logic          we_b,
    input  logic          ssr_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] din_b,
    output logic [DW-1:0] dout_b
);

    logic     clk_ai, clk_bi;
    port_op_e op_a, op_b;
    logic     wr_req_a, wr_req_b;
    logic     wr_b_ok;

    logic [DW-1:0] wa0, wa1, wb0, wb1;
    logic          ta0, ta1, tb0, tb1;
    logic          ta_at_b, tb_at_a;
    logic [DW-1:0] word_a, word_b;

    // Port A front end.
    dpram_nochg_front #(
        .INV_CLK(INV_CLK_A), .INV_EN(INV_EN_A),
        .INV_WE(INV_WE_A),   .INV_SSR(INV_SSR_A)
    ) u_front_a (
        .clk_pin(clk_a), .en_pin(en_a), .we_pin(we_a), .ssr_pin(ssr_a),
        .clk_int(clk_ai), .op(op_a), .wr_req(wr_req_a)
    );

    // Port B front end.
    dpram_nochg_front #(
        .INV_CLK(INV_CLK_B), .INV_EN(INV_EN_B),
        .INV_WE(INV_WE_B),   .INV_SSR(INV_SSR_B)
    ) u_front_b (
        .clk_pin(clk_b), .en_pin(en_b), .we_pin(we_b), .ssr_pin(ssr_b),
        .clk_int(clk_bi), .op(op_b), .wr_req(wr_req_b)
    );

    // Port B yields to a same-address write from port A.
    assign wr_b_ok = wr_req_b & ~(wr_req_a & (addr_a == addr_b));

    // Bank written by port A (primary: newest when tags agree).
    dpram_nochg_bank #(
        .AW(AW), .DW(DW), .PRIMARY(1'b1),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) u_bank_a (
        .clk(clk_ai), .rst_n(rst_n),
        .wr_en(wr_req_a), .wr_addr(addr_a), .wr_data(din_a),
        .peer_tag(tb_at_a), .peer_addr(addr_b), .tag_at_peer(ta_at_b),
        .rd_addr0(addr_a), .rd_word0(wa0), .rd_tag0(ta0),
        .rd_addr1(addr_b), .rd_word1(wa1), .rd_tag1(ta1)
    );

    // Bank written by port B (secondary: newest when tags differ).
    dpram_nochg_bank #(
        .AW(AW), .DW(DW), .PRIMARY(1'b0),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) u_bank_b (
        .clk(clk_bi), .rst_n(rst_n),
        .wr_en(wr_b_ok), .wr_addr(addr_b), .wr_data(din_b),
        .peer_tag(ta_at_b), .peer_addr(addr_a), .tag_at_peer(tb_at_a),
        .rd_addr0(addr_a), .rd_word0(wb0), .rd_tag0(tb0),
        .rd_addr1(addr_b), .rd_word1(wb1), .rd_tag1(tb1)
    );

    // Merge: pick the bank holding the newest copy for each port.
    assign word_a = (ta0 ^ tb0) ? wb0 : wa0;
    assign word_b = (ta1 ^ tb1) ? wb1 : wa1;

    // Port A output register.
    dpram_nochg_outreg #(
        .DW(DW), .INIT_VAL(INIT_A), .SET_VAL(SRVAL_A)
    ) u_out_a (
        .clk(clk_ai), .rst_n(rst_n), .op(op_a), .rd_word(word_a), .dout(dout_a)
    );

    // Port B output register.
    dpram_nochg_outreg #(
        .DW(DW), .INIT_VAL(INIT_B), .SET_VAL(SRVAL_B)
    ) u_out_b (
        .clk(clk_bi), .rst_n(rst_n), .op(op_b), .rd_word(word_b), .dout(dout_b)
    );

endmodule

// File: rtl/dpram_nochg_chk.sv
// Module: protocol checker for the output registers, bound to the top.
// Assumes: the same inversion parameters as the design it watches.
module dpram_nochg_chk #(
    parameter int            DW        = 18,
    parameter logic [DW-1:0] INIT_A    = '0,
    parameter logic [DW-1:0] SRVAL_A   = '0,
    parameter logic [DW-1:0] INIT_B    = '0,
    parameter logic [DW-1:0] SRVAL_B   = '0,
    parameter bit            INV_CLK_A = 1'b0,
    parameter bit            INV_EN_A  = 1'b0,
    parameter bit            INV_WE_A  = 1'b0,
    parameter bit            INV_SSR_A = 1'b0,
    parameter bit            INV_CLK_B = 1'b0,
    parameter bit            INV_EN_B  = 1'b0,
    parameter bit            INV_WE_B  = 1'b0,
    parameter bit            INV_SSR_B = 1'b0
) (
    input logic          rst_n,
    input logic          clk_a,
    input logic          en_a,
    input logic          we_a,
    input logic          ssr_a,
    input logic [DW-1:0] dout_a,
    input logic          clk_b,
    input logic          en_b,
    input logic          we_b,
    input logic          ssr_b,
    input logic [DW-1:0] dout_b
);

    logic ca, cb, ea, eb, wa, wb, sa, sb;
    assign ca = clk_a ^ INV_CLK_A;
    assign cb = clk_b ^ INV_CLK_B;
    assign ea = en_a  ^ INV_EN_A;
    assign eb = en_b  ^ INV_EN_B;
    assign wa = we_a  ^ INV_WE_A;
    assign wb = we_b  ^ INV_WE_B;
    assign sa = ssr_a ^ INV_SSR_A;
    assign sb = ssr_b ^ INV_SSR_B;

    AST_INIT_A: assert property (@(posedge ca) !rst_n |=> dout_a == INIT_A); // R1
    AST_INIT_B: assert property (@(posedge cb) !rst_n |=> dout_b == INIT_B); // R1
    AST_WRITE_HOLD_A: assert property (@(posedge ca) disable iff (!rst_n)
        ea && wa && !sa |=> $stable(dout_a)); // R4
    AST_WRITE_HOLD_B: assert property (@(posedge cb) disable iff (!rst_n)
        eb && wb && !sb |=> $stable(dout_b)); // R4
    AST_IDLE_HOLD_A: assert property (@(posedge ca) disable iff (!rst_n)
        !ea |=> $stable(dout_a)); // R5
    AST_IDLE_HOLD_B: assert property (@(posedge cb) disable iff (!rst_n)
        !eb |=> $stable(dout_b)); // R5
    AST_SET_A: assert property (@(posedge ca) disable iff (!rst_n)
        ea && sa |=> dout_a == SRVAL_A); // R6
    AST_SET_B: assert property (@(posedge cb) disable iff (!rst_n)
        eb && sb |=> dout_b == SRVAL_B); // R6

endmodule

bind dpram_nochg dpram_nochg_chk #(
    .DW(DW), .INIT_A(INIT_A), .SRVAL_A(SRVAL_A), .INIT_B(INIT_B), .SRVAL_B(SRVAL_B),
    .INV_CLK_A(INV_CLK_A), .INV_EN_A(INV_EN_A), .INV_WE_A(INV_WE_A), .INV_SSR_A(INV_SSR_A),
    .INV_CLK_B(INV_CLK_B), .INV_EN_B(INV_EN_B), .INV_WE_B(INV_WE_B), .INV_SSR_B(INV_SSR_B)
) u_chk (
    .rst_n(rst_n),
    .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .dout_a(dout_a),
    .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .dout_b(dout_b)
);

// File: tb/sim_dpram_nochg.sv
module sim_dpram_nochg;

    localparam int AW = 10;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] IBASE = 18'h00100;
    localparam logic [DW-1:0] ISTEP = 18'h00003;
    localparam logic [DW-1:0] IA = 18'h2AAAA;
    localparam logic [DW-1:0] SA = 18'h15555;
    localparam logic [DW-1:0] IB = 18'h0F0F0;
    localparam logic [DW-1:0] SB = 18'h30303;
    // R10: port A enable, port B write enable and port B set are active low here.
    localparam bit IEN_A = 1'b1;
    localparam bit IWE_B = 1'b1;
    localparam bit ISSR_B = 1'b1;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst_n;
    // Effective (active-high) stimulus; pins are derived with the inversion.
    logic ea, wa, sa, eb, wb, sb;
    logic [AW-1:0] aa, ab;
    logic [DW-1:0] da, db;
    logic [DW-1:0] dout_a, dout_b;

    dpram_nochg #(
        .AW(AW), .DW(DW), .INIT_BASE(IBASE), .INIT_STEP(ISTEP),
        .INIT_A(IA), .SRVAL_A(SA), .INIT_B(IB), .SRVAL_B(SB),
        .INV_EN_A(IEN_A), .INV_WE_B(IWE_B), .INV_SSR_B(ISSR_B)
    ) u0 (
        .rst_n(rst_n),
        .clk_a(clk), .en_a(ea ^ IEN_A), .we_a(wa), .ssr_a(sa),
        .addr_a(aa), .din_a(da), .dout_a(dout_a),
        .clk_b(clk), .en_b(eb), .we_b(wb ^ IWE_B), .ssr_b(sb ^ ISSR_B),
        .addr_b(ab), .din_b(db), .dout_b(dout_b)
    );

    // Reference model state.
    logic [DW-1:0] mm [DEPTH];
    logic [DW-1:0] xa, xb;
    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;
    string req = "R1";

    task automatic model_edge();
        logic [DW-1:0] na, nb;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mm[i] = IBASE + DW'(i) * ISTEP;
            xa = IA;
            xb = IB;
            return;
        end
        na = xa;
        nb = xb;
        if (ea && sa) na = SA; else if (ea && !wa) na = mm[aa];
        if (eb && sb) nb = SB; else if (eb && !wb) nb = mm[ab];
        if (eb && wb) mm[ab] = db;
        if (ea && wa) mm[aa] = da;   // applied last: port A wins
        xa = na;
        xb = nb;
    endtask

    task automatic compare();
        vectors += 2;
        if (dout_a !== xa) begin
            misses++;
            $display("FAIL %s port A dout=%h expected %h", req, dout_a, xa);
        end
        if (dout_b !== xb) begin
            misses++;
            $display("FAIL %s port B dout=%h expected %h", req, dout_b, xb);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        ea = 0; wa = 0; sa = 0; eb = 0; wb = 0; sb = 0;
    endtask

    task automatic rd_a(input int a);
        idle(); ea = 1; aa = AW'(a); step();
    endtask

    task automatic rd_b(input int a);
        idle(); eb = 1; ab = AW'(a); step();
    endtask

    task automatic wr_a(input int a, input logic [DW-1:0] d);
        idle(); ea = 1; wa = 1; aa = AW'(a); da = d; step();
    endtask

    task automatic wr_b(input int a, input logic [DW-1:0] d);
        idle(); eb = 1; wb = 1; ab = AW'(a); db = d; step();
    endtask

    initial begin
        rst_n = 0; idle(); aa = '0; ab = '0; da = '0; db = '0;
        @(negedge clk);
        req = "R1";
        step(); step();
        rst_n = 1;
        step();                                   // R1: outputs hold reset constants
        req = "R2";
        rd_a(0); rd_a(5); rd_b(DEPTH - 1); rd_b(77);
        req = "R3";
        wr_a(12, 18'h12345); rd_a(12);
        req = "R4";
        rd_a(12); wr_a(12, 18'h3ABCD); idle(); step(); rd_a(12);
        wr_b(40, 18'h0BEEF); rd_b(40);
        req = "R5";
        idle(); wa = 1; aa = 12; da = 18'h00001; step();   // en off: nothing stored
        rd_a(12);
        idle(); wb = 1; sb = 1; ab = 40; db = 18'h00002; step();
        rd_b(40);
        req = "R6";
        idle(); ea = 1; sa = 1; aa = 12; step();
        idle(); eb = 1; sb = 1; ab = 40; step();
        req = "R7";
        idle(); ea = 1; wa = 1; sa = 1; aa = 20; da = 18'h2F00F; step();
        rd_a(20);
        idle(); eb = 1; wb = 1; sb = 1; ab = 21; db = 18'h1C0C0; step();
        rd_b(21);
        req = "R8";
        wr_a(300, 18'h01111); rd_b(300);
        wr_b(301, 18'h02222); rd_a(301);
        wr_b(300, 18'h03333); rd_a(300);
        req = "R9";
        idle(); ea = 1; wa = 1; eb = 1; wb = 1; aa = 50; ab = 50;
        da = 18'h0AAAA; db = 18'h05555; step();
        rd_a(50); rd_b(50);
        req = "R11";
        idle(); ea = 1; wa = 1; aa = 60; da = 18'h06060;
        eb = 1; ab = 61; step();
        idle(); ea = 1; aa = 61; eb = 1; wb = 1; ab = 60; db = 18'h07070; step();
        rd_a(60);
        req = "R10 R11";
        for (int n = 0; n < 3000; n++) begin
            ea = 1'($urandom); wa = 1'($urandom); sa = (($urandom % 8) == 0);
            eb = 1'($urandom); wb = 1'($urandom); sb = (($urandom % 8) == 0);
            aa = AW'($urandom % 8); ab = AW'($urandom % 8);
            da = DW'($urandom); db = DW'($urandom);
            step();
        end
        idle();
        for (int i = 0; i < 8; i++) begin
            rd_a(i); rd_b(i);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule